// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a 64-bit watchdog. A software agent arms it by writing two key values in a fixed order into a control register. Once it is armed, a free-running 64-bit counter climbs toward a programmed 64-bit period. If software lets the counter reach the period, the block raises a reset request to the rest of the chip. Software must therefore service the watchdog now and then by writing the same two keys again, which clears the counter. Any key other than the two valid values, written while the watchdog is armed, raises the reset request at once. This catches software that has run away and is writing stray values.

The watchdog sits behind a simple single-cycle write port with a byte address and a 32-bit data word. A global configuration register must select watchdog mode and release both counter halves before any key is accepted. The reset request is a pulse of fixed length. When the pulse ends, the key state machine, the counter and the enable bit return to their initial values.

The current key state and counter value are visible on output ports, so the surrounding logic can observe them.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the state output reads 0 (idle), the reset request is low and the counter output is 0.
- R2: A write to the control register (address 0x28) is ignored unless the global register (address 0x24) holds 2 in bits 3:2 and 2'b11 in bits 1:0.
- R3: In the control register, bit 14 is the enable bit and bits 31:16 are the key. A key is accepted only if the enable bit is already set or is set in the same write. Otherwise the key is ignored.
- R4: Once set, the enable bit stays set. Only the block reset or the end of a reset-request pulse clears it.
- R5: From idle (0), key 0xA5C6 moves the state to pre-active (1). From pre-active, key 0xDA7E moves it to active (2). Any other key in idle or pre-active changes nothing.
- R6: In active (2) and service-pending (3), the counter rises by one each clock. The counter words (0x10 low, 0x14 high) and the period words (0x18 low, 0x1C high) can be written only in idle or pre-active.
- R7: In active or service-pending, when the counter equals the period, the state becomes 4 (bite) on the next clock. With a period of 0 and a counter of 0, the bite comes one clock after arming.
- R8: In active, key 0xA5C6 moves the state to service-pending (3). In service-pending, 0xDA7E returns the state to active and clears the counter. Key 0xDA7E written in active is ignored. A timeout takes priority over a service.
- R9: In active or service-pending, any key other than 0xA5C6 and 0xDA7E moves the state to bite (4) on the next clock.
- R10: In bite (4), the reset request is high for exactly 16 clocks. Then the state returns to idle, the counter reads 0 and the enable bit is cleared. The period words keep their value.
- R11: Writes to the global register are ignored whenever the state is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 8 | Byte address of the register written |
| wr_data | input | 32 | Write data |
| wdt_rst_o | output | 1 | Reset request, high during the bite pulse |
| wdt_state_o | output | 3 | Key state: 0 idle, 1 pre-active, 2 active, 3 service-pending, 4 bite |
| wdt_count_o | output | 64 | Current counter value |

## Verification
The assertions assume that the write port carries at most one word per cycle and that wr_en, wr_addr and wr_data are stable around the rising clock edge. They also assume the reset is held long enough for the internal synchronizer to clear. The bench drives every input half a cycle away from the sampling edge and pulses wr_en for exactly one cycle per write. It holds reset for several cycles and waits for the synchronized release before the first write. Periods are kept small enough that each timeout falls within a few dozen cycles.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [2:0] {
    WD_IDLE = 3'd0,
    WD_PRE  = 3'd1,
    WD_LIVE = 3'd2,
    WD_SVC  = 3'd3,
    WD_BITE = 3'd4
  } wd_state_e;

  // Global mode field value selecting watchdog operation
  localparam logic [1:0] MODE_WATCHDOG = 2'd2;
  localparam logic [1:0] HALVES_LIVE   = 2'b11;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs #(
  parameter int ADDR_W  = 8,
  parameter int KEY_W   = 16,
  parameter int OFF_GLB = 'h24,
  parameter int OFF_CTL = 'h28,
  parameter int OFF_CLO = 'h10,
  parameter int OFF_CHI = 'h14,
  parameter int OFF_PLO = 'h18,
  parameter int OFF_PHI = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        glb_field,
  input  logic              en_field,
  input  logic [KEY_W-1:0]  key_field,
  input  logic              fsm_idle,
  input  logic              fsm_locked,
  input  logic              wipe,
  output logic              mode_ok,
  output logic              en_o,
  output logic              key_stb,
  output logic [KEY_W-1:0]  key_val,
  output logic              cnt_lo_we,
  output logic              cnt_hi_we,
  output logic              prd_lo_we,
  output logic              prd_hi_we
);
  import wdk_pkg::*;

  logic [3:0] glb_q, glb_d;
  logic       en_q, en_d;
  logic       hit_glb, hit_ctl;
  logic       glb_ce;

  assign hit_glb = wr_en && (wr_addr == ADDR_W'(OFF_GLB));
  assign hit_ctl = wr_en && (wr_addr == ADDR_W'(OFF_CTL));
  assign mode_ok = (glb_q[3:2] == MODE_WATCHDOG) && (glb_q[1:0] == HALVES_LIVE);

  // Global register is frozen once the key sequence has started
  assign glb_ce = hit_glb && fsm_idle;

  always_comb begin
    glb_d = glb_q;
    if (glb_ce) glb_d = glb_field;
  end

  always_comb begin
    en_d = en_q;
    if (wipe) en_d = 1'b0;
    else if (hit_ctl && mode_ok && en_field) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= '0;
      en_q  <= 1'b0;
    end else begin
      glb_q <= glb_d;
      en_q  <= en_d;
    end
  end

  assign en_o      = en_q;
  assign key_stb   = hit_ctl && mode_ok && (en_q || en_field) && !wipe;
  assign key_val   = key_field;
  assign cnt_lo_we = wr_en && !fsm_locked && (wr_addr == ADDR_W'(OFF_CLO));
  assign cnt_hi_we = wr_en && !fsm_locked && (wr_addr == ADDR_W'(OFF_CHI));
  assign prd_lo_we = wr_en && !fsm_locked && (wr_addr == ADDR_W'(OFF_PLO));
  assign prd_hi_we = wr_en && !fsm_locked && (wr_addr == ADDR_W'(OFF_PHI));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_lo_we,
  input  logic               cnt_hi_we,
  input  logic               prd_lo_we,
  input  logic               prd_hi_we,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic               run,
  input  logic               clr,
  output logic [CNT_W-1:0]   count,
  output logic               hit
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] prd_q, prd_d;
  logic [1:0]       cnt_we, prd_we;

  assign cnt_we = {cnt_hi_we, cnt_lo_we};
  assign prd_we = {prd_hi_we, prd_lo_we};

  // Counter: clear beats run, run beats a word load
  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (cnt_we[w]) cnt_d[w*HALF +: HALF] = wdata;
      end
    end
  end

  always_comb begin
    prd_d = prd_q;
    for (int w = 0; w < 2; w++) begin
      if (prd_we[w]) prd_d[w*HALF +: HALF] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      prd_q <= prd_d;
    end
  end

  assign count = cnt_q;
  assign hit   = (cnt_q == prd_q);
endmodule

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm #(
  parameter int              KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY_ARM  = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_FIRE = 16'hDA7E,
  parameter int              PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_stb,
  input  logic [KEY_W-1:0] key_val,
  input  logic             hit,
  output logic [2:0]       state_o,
  output logic             run,
  output logic             clr,
  output logic             wipe,
  output logic             idle,
  output logic             locked
);
  import wdk_pkg::*;

  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  wd_state_e       st_q, st_d;
  logic [PW-1:0]   pc_q, pc_d;
  logic            armed, is_arm, is_fire, bad_key, svc_done;

  assign armed    = (st_q == WD_LIVE) || (st_q == WD_SVC);
  assign is_arm   = (key_val == KEY_ARM);
  assign is_fire  = (key_val == KEY_FIRE);
  assign bad_key  = key_stb && !is_arm && !is_fire;
  assign wipe     = (st_q == WD_BITE) && (pc_q == PW'(PULSE_LEN - 1));
  assign svc_done = (st_q == WD_SVC) && key_stb && is_fire && !hit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WD_IDLE: if (key_stb && is_arm) st_d = WD_PRE;
      WD_PRE:  if (key_stb && is_fire) st_d = WD_LIVE;
      WD_LIVE: begin
        if (hit || bad_key)          st_d = WD_BITE;
        else if (key_stb && is_arm)  st_d = WD_SVC;
      end
      WD_SVC: begin
        if (hit || bad_key)          st_d = WD_BITE;
        else if (key_stb && is_fire) st_d = WD_LIVE;
      end
      WD_BITE: if (wipe) st_d = WD_IDLE;
      default: st_d = WD_IDLE;
    endcase
  end

  always_comb begin
    pc_d = pc_q;
    if (st_q == WD_BITE) pc_d = pc_q + PW'(1);
    else                 pc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WD_IDLE;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign state_o = st_q;
  assign run     = armed && !hit;
  assign clr     = svc_done || wipe;
  assign idle    = (st_q == WD_IDLE);
  assign locked  = armed || (st_q == WD_BITE);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 64,
  parameter int KEY_W     = 16,
  parameter int KEY_LSB   = 16,
  parameter int EN_BIT    = 14,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_rst_o,
  output logic [2:0]        wdt_state_o,
  output logic [CNT_W-1:0]  wdt_count_o
);
  import wdk_pkg::*;

  logic [1:0]       sync_q;
  logic             srst_n;
  logic             mode_ok, en_q, key_stb;
  logic [KEY_W-1:0] key_val;
  logic             cnt_lo_we, cnt_hi_we, prd_lo_we, prd_hi_we;
  logic             run, clr, wipe, fsm_idle, fsm_locked, cnt_hit;
  logic [2:0]       fsm_state;
  logic [CNT_W-1:0] cnt_val;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  wdk_regs #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W)
  ) u_regs (
    .clk(clk), .rst_n(srst_n),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .glb_field(wr_data[3:0]),
    .en_field(wr_data[EN_BIT]),
    .key_field(wr_data[KEY_LSB +: KEY_W]),
    .fsm_idle(fsm_idle), .fsm_locked(fsm_locked), .wipe(wipe),
    .mode_ok(mode_ok), .en_o(en_q),
    .key_stb(key_stb), .key_val(key_val),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
    .prd_lo_we(prd_lo_we), .prd_hi_we(prd_hi_we)
  );

  wdk_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(srst_n),
    .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
    .prd_lo_we(prd_lo_we), .prd_hi_we(prd_hi_we),
    .wdata(wr_data[CNT_W/2-1:0]),
    .run(run), .clr(clr),
    .count(cnt_val), .hit(cnt_hit)
  );

  wdk_keyfsm #(
    .KEY_W(KEY_W), .PULSE_LEN(PULSE_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(srst_n),
    .key_stb(key_stb), .key_val(key_val), .hit(cnt_hit),
    .state_o(fsm_state), .run(run), .clr(clr), .wipe(wipe),
    .idle(fsm_idle), .locked(fsm_locked)
  );

  assign wdt_rst_o   = (fsm_state == WD_BITE);
  assign wdt_state_o = fsm_state;
  assign wdt_count_o = cnt_val;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W     = 64,
  parameter int KEY_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             srst_n,
  input logic [2:0]       fsm_state,
  input logic             cnt_hit,
  input logic [CNT_W-1:0] cnt_val,
  input logic             key_stb,
  input logic [KEY_W-1:0] key_val,
  input logic             wipe,
  input logic             en_q,
  input logic             mode_ok,
  input logic             wdt_rst_o
);
  logic [7:0] plen;
  logic       armed;

  assign armed = (fsm_state == 3'd2) || (fsm_state == 3'd3);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        plen <= '0;
    else if (wdt_rst_o) plen <= plen + 8'd1;
    else                plen <= '0;
  end

  // R10
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wdt_rst_o |-> (plen < 8'(PULSE_LEN)));
  // R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(wdt_rst_o) |-> ($past(plen) == 8'(PULSE_LEN - 1)));
  // R9
  bad_key_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (key_stb && armed && (key_val != 16'hA5C6) && (key_val != 16'hDA7E))
      |=> (fsm_state == 3'd4));
  // R7
  timeout_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (armed && cnt_hit) |=> (fsm_state == 3'd4));
  // R5
  idle_exit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fsm_state == 3'd0) |=> ((fsm_state == 3'd0) || (fsm_state == 3'd1)));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((fsm_state == 3'd2) && !cnt_hit) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));
  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (en_q && !wipe) |=> en_q);
  // R11
  glb_lock_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fsm_state != 3'd0) |=> $stable(mode_ok));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .srst_n(srst_n), .fsm_state(fsm_state), .cnt_hit(cnt_hit),
  .cnt_val(cnt_val), .key_stb(key_stb), .key_val(key_val), .wipe(wipe),
  .en_q(en_q), .mode_ok(mode_ok), .wdt_rst_o(wdt_rst_o)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam logic [7:0] A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18, A_PHI = 8'h1C;
  localparam logic [7:0] A_GLB = 8'h24, A_CTL = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wdt_rst_o;
  logic [2:0]  wdt_state_o;
  logic [63:0] wdt_count_o;

  always #10 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_rst_o(wdt_rst_o), .wdt_state_o(wdt_state_o), .wdt_count_o(wdt_count_o)
  );

  typedef struct {
    string       tag;
    logic [2:0]  st;
    logic        rs;
    logic [63:0] cnt;
    bit          use_cnt;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  function automatic logic [31:0] kw(input logic [15:0] k, input bit en);
    return {k, 1'b0, en, 14'b0};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [2:0] st, input logic rs,
                            input logic [63:0] c, input bit uc);
    exp_t e;
    e.tag = tag; e.st = st; e.rs = rs; e.cnt = c; e.use_cnt = uc;
    q.push_back(e);
    #2;
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      #1;
      e = q.pop_front();
      n_run++;
      if (wdt_state_o !== e.st || wdt_rst_o !== e.rs || (e.use_cnt && wdt_count_o !== e.cnt)) begin
        n_fail++;
        $display("FAIL %s: state=%0d rst=%0b count=%0d expected state=%0d rst=%0b count=%0d",
                 e.tag, wdt_state_o, wdt_rst_o, wdt_count_o, e.st, e.rs, e.cnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no completion expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(4);
    #2 rst_n = 1'b1;
    idle(4);
    #2;
    expect_out("R1 reset state", 3'd0, 1'b0, 64'd0, 1'b1);

    wr(A_CTL, kw(16'hA5C6, 1'b1));
    expect_out("R2 key ignored without watchdog mode", 3'd0, 1'b0, 64'd0, 1'b1);
    wr(A_GLB, 32'h0000_000B);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    expect_out("R3 key ignored with enable clear", 3'd0, 1'b0, 64'd0, 1'b1);
    wr(A_CTL, 32'h0000_4000);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    expect_out("R4 sticky enable accepts first key", 3'd1, 1'b0, 64'd0, 1'b1);
    wr(A_CTL, kw(16'h1234, 1'b0));
    expect_out("R5 stray key in pre-active ignored", 3'd1, 1'b0, 64'd0, 1'b1);

    wr(A_PLO, 32'd20); wr(A_PHI, 32'd0); wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(A_CTL, kw(16'hDA7E, 1'b0));
    expect_out("R5 second key arms", 3'd2, 1'b0, 64'd0, 1'b1);
    idle(5);
    expect_out("R6 counts each clock", 3'd2, 1'b0, 64'd5, 1'b1);
    wr(A_CLO, 32'h100);
    expect_out("R6 counter write ignored while armed", 3'd2, 1'b0, 64'd6, 1'b1);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    expect_out("R8 first service key", 3'd3, 1'b0, 64'd7, 1'b1);
    wr(A_CTL, kw(16'hDA7E, 1'b0));
    expect_out("R8 service clears counter", 3'd2, 1'b0, 64'd0, 1'b1);
    idle(20);
    expect_out("R7 count at period, no bite yet", 3'd2, 1'b0, 64'd20, 1'b1);
    idle(1);
    expect_out("R7 timeout bites", 3'd4, 1'b1, 64'd20, 1'b1);
    idle(15);
    expect_out("R10 pulse still high at 16th clock", 3'd4, 1'b1, 64'd20, 1'b1);
    idle(1);
    expect_out("R10 back to idle after pulse", 3'd0, 1'b0, 64'd0, 1'b1);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    expect_out("R10 enable cleared by pulse", 3'd0, 1'b0, 64'd0, 1'b1);

    wr(A_PLO, 32'd1000);
    wr(A_CTL, 32'h0000_4000);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    wr(A_CTL, kw(16'hDA7E, 1'b0));
    expect_out("R5 re-armed", 3'd2, 1'b0, 64'd0, 1'b1);
    wr(A_CTL, kw(16'hDA7E, 1'b0));
    expect_out("R8 second key alone ignored in active", 3'd2, 1'b0, 64'd1, 1'b1);
    wr(A_GLB, 32'd0);
    expect_out("R11 global write while armed", 3'd2, 1'b0, 64'd2, 1'b1);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    expect_out("R11 mode kept, service key accepted", 3'd3, 1'b0, 64'd3, 1'b1);
    wr(A_CTL, kw(16'hBEEF, 1'b0));
    expect_out("R9 wrong key bites", 3'd4, 1'b1, 64'd0, 1'b0);
    idle(15);
    expect_out("R10 wrong-key pulse length", 3'd4, 1'b1, 64'd0, 1'b0);
    idle(1);
    expect_out("R10 idle after wrong-key pulse", 3'd0, 1'b0, 64'd0, 1'b1);

    wr(A_PLO, 32'd0);
    wr(A_CTL, 32'h0000_4000);
    wr(A_CTL, kw(16'hA5C6, 1'b0));
    wr(A_CTL, kw(16'hDA7E, 1'b0));
    expect_out("R7 armed with zero period", 3'd2, 1'b0, 64'd0, 1'b1);
    idle(1);
    expect_out("R7 zero period bites next clock", 3'd4, 1'b1, 64'd0, 1'b1);
    idle(16);
    expect_out("R10 idle after zero-period pulse", 3'd0, 1'b0, 64'd0, 1'b1);

    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule